// File: doc/BRIEF.md
# Speed-Adaptive Clock and Threshold Calibrator

This block tunes a quiescent-current sensor to the process corner of the die it sits on. Before any current measurement starts, it opens a fixed window, timed in cycles of the reference clock, and counts the cycles of an on-chip ring oscillator during that window. The oscillator count is a direct measure of how fast the silicon is. The count picks one of four speed bins. Each bin selects a divide ratio for the clock that drives the current-measurement counter, and loads a per-bin defect threshold into a threshold register. Faster dies leak more, so they get a faster measurement clock and a wider allowed difference.

The oscillator count is kept in the oscillator clock domain. When the window closes, the count is latched there and handed to the reference domain by flipping a toggle signal, which passes through a synchronizer. The calibration runs once each time the test enable goes high. A done flag shows that the divide code and the threshold are both valid. The threshold register can also be written directly at any time, so a tester can sweep the limit around its calibrated value.

Top module: `speed_calibrator`

## Requirements
- R1: While reset is asserted, `div_code` is 3, `thr_value` is 0 and `cal_done` is 0.
- R2: A calibration starts on the first reference-clock edge at which `test_en` is high while the block is idle. The oscillator is counted for WINDOW_CYCLES reference cycles (default 1024). `cal_done` rises no earlier than WINDOW_CYCLES+2 and no later than WINDOW_CYCLES+16 reference edges after the start edge.
- R3: `div_code` encodes the divide ratio: 0 means divide by 1, 1 by 2, 2 by 4 and 3 by 8. An oscillator count of at least BIN_HI (3072) gives code 0. At least BIN_MID (1536) gives code 1. At least BIN_LO (768) gives code 2. Any lower count gives code 3.
- R4: On the edge where `cal_done` rises, `thr_value` takes the table entry for the chosen code: 160 for code 0, 80 for code 1, 40 for code 2 and 20 for code 3.
- R5: While `test_en` stays high after completion, `cal_done` stays 1 and `div_code` does not change. Another calibration needs `test_en` to go low and then high again.
- R6: When `test_en` is sampled low, `cal_done` is 0 after that edge, and `div_code` and `thr_value` keep their values. If `test_en` drops during a calibration, the calibration is dropped and nothing is loaded.
- R7: When `thr_wr_en` is high at an edge, `thr_value` equals `thr_wr_data` after that edge, in any state. A direct write takes priority over a calibration load in the same cycle.
- R8: During a calibration, until `cal_done` rises, `div_code` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | External reference clock; times the window and runs the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Ring-oscillator clock to be measured |
| test_en | input | 1 | Sensor test enable; a rising level starts a calibration |
| thr_wr_en | input | 1 | Direct write strobe for the threshold register |
| thr_wr_data | input | THR_W (12) | Value to write into the threshold register |
| div_code | output | 2 | Selected measurement-clock divide code (0:/1, 1:/2, 2:/4, 3:/8) |
| thr_value | output | THR_W (12) | Current contents of the threshold register |
| cal_done | output | 1 | Divide code and threshold are valid for this run |

## Verification
The assertions assume that `test_en` stays low for at least 16 reference cycles between runs. This lets a late toggle from a dropped run settle while the sequencer is idle. They also assume the oscillator period is at most twice the reference period, so the return path fits in the R2 latency bound. The stimulus keeps the oscillator between 2 ns and 16 ns, with a period chosen so that the count is far from any bin boundary. It changes the period only while `test_en` is low, and it waits at least 20 idle cycles before each start. Direct threshold writes occur either early in a window or after completion, never in the cycle of a load.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int unsigned NUM_BINS   = 4;
    localparam int unsigned DIV_CODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } cal_state_e;

    typedef logic [DIV_CODE_W-1:0] div_code_t;
endpackage

// File: rtl/osc_speed_counter.sv
module osc_speed_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_async,
    output logic [CNT_W-1:0] count_o,
    output logic             toggle_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [1:0]       gsync;
        logic             gprev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             tog;
    } osc_regs_t;

    osc_regs_t q, d;

    always_comb begin
        d       = q;
        d.gsync = {q.gsync[0], gate_async};
        d.gprev = q.gsync[1];
        if (q.gsync[1] && !q.gprev) begin
            d.cnt = '0;
        end else if (q.gsync[1] && (q.cnt != CNT_MAX)) begin
            d.cnt = q.cnt + 1'b1;
        end
        if (!q.gsync[1] && q.gprev) begin
            d.cap = q.cnt;
            d.tog = ~q.tog;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o  = q.cap;
    assign toggle_o = q.tog;
endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic pulse_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] s;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d   = q;
        d.s = {q.s[DEPTH-2:0], tog_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_o = q.s[DEPTH-1] ^ q.s[DEPTH-2];
endmodule

// File: rtl/speed_binner.sv
module speed_binner
    import cal_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned THR_W   = 12,
    parameter int unsigned BIN_HI  = 3072,
    parameter int unsigned BIN_MID = 1536,
    parameter int unsigned BIN_LO  = 768,
    parameter logic [NUM_BINS-1:0][THR_W-1:0] THR_TABLE =
        {12'd20, 12'd40, 12'd80, 12'd160}
) (
    input  logic [CNT_W-1:0] count_i,
    output div_code_t        code_o,
    output logic [THR_W-1:0] thr_o
);
    localparam logic [CNT_W-1:0] HI_C  = CNT_W'(BIN_HI);
    localparam logic [CNT_W-1:0] MID_C = CNT_W'(BIN_MID);
    localparam logic [CNT_W-1:0] LO_C  = CNT_W'(BIN_LO);

    always_comb begin
        if (count_i >= HI_C) begin
            code_o = 2'd0;
        end else if (count_i >= MID_C) begin
            code_o = 2'd1;
        end else if (count_i >= LO_C) begin
            code_o = 2'd2;
        end else begin
            code_o = 2'd3;
        end
        thr_o = THR_TABLE[code_o];
    end
endmodule

// File: rtl/speed_calibrator.sv
module speed_calibrator
    import cal_pkg::*;
#(
    parameter int unsigned WINDOW_CYCLES = 1024,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned THR_W         = 12,
    parameter int unsigned BIN_HI        = 3072,
    parameter int unsigned BIN_MID       = 1536,
    parameter int unsigned BIN_LO        = 768,
    parameter logic [NUM_BINS-1:0][THR_W-1:0] THR_TABLE =
        {12'd20, 12'd40, 12'd80, 12'd160}
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             osc_clk,
    input  logic             test_en,
    input  logic             thr_wr_en,
    input  logic [THR_W-1:0] thr_wr_data,
    output logic [1:0]       div_code,
    output logic [THR_W-1:0] thr_value,
    output logic             cal_done
);
    localparam int unsigned      WIN_W    = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);

    typedef struct packed {
        cal_state_e       state;
        logic [WIN_W-1:0] win_cnt;
        logic             gate;
        div_code_t        div;
        logic [THR_W-1:0] thr;
        logic             done;
    } cal_regs_t;

    cal_regs_t q, d;

    logic [CNT_W-1:0] osc_count;
    logic             osc_toggle;
    logic             cnt_ready;
    div_code_t        bin_code;
    logic [THR_W-1:0] bin_thr;

    osc_speed_counter #(.CNT_W(CNT_W)) i_osc_cnt (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .gate_async (q.gate),
        .count_o    (osc_count),
        .toggle_o   (osc_toggle)
    );

    toggle_sync #(.STAGES(2)) i_tog_sync (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .tog_async (osc_toggle),
        .pulse_o   (cnt_ready)
    );

    speed_binner #(
        .CNT_W     (CNT_W),
        .THR_W     (THR_W),
        .BIN_HI    (BIN_HI),
        .BIN_MID   (BIN_MID),
        .BIN_LO    (BIN_LO),
        .THR_TABLE (THR_TABLE)
    ) i_binner (
        .count_i (osc_count),
        .code_o  (bin_code),
        .thr_o   (bin_thr)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (test_en) begin
                    d.state   = ST_WINDOW;
                    d.win_cnt = '0;
                    d.gate    = 1'b1;
                    d.done    = 1'b0;
                end
            end
            ST_WINDOW: begin
                if (q.win_cnt == WIN_LAST) begin
                    d.state = ST_WAIT;
                    d.gate  = 1'b0;
                end else begin
                    d.win_cnt = q.win_cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (cnt_ready) begin
                    d.state = ST_DONE;
                    d.div   = bin_code;
                    d.thr   = bin_thr;
                    d.done  = 1'b1;
                end
            end
            ST_DONE: begin
                d.done = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
        if (!test_en) begin
            d.state = ST_IDLE;
            d.gate  = 1'b0;
            d.done  = 1'b0;
        end
        if (thr_wr_en) begin
            d.thr = thr_wr_data;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.win_cnt <= '0;
            q.gate    <= 1'b0;
            q.div     <= 2'd3;
            q.thr     <= '0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign div_code  = q.div;
    assign thr_value = q.thr;
    assign cal_done  = q.done;

    AST_EN_LOW_CLEARS_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !test_en |=> !cal_done); // R6

    AST_DIRECT_WRITE_WINS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        thr_wr_en |=> (thr_value == $past(thr_wr_data))); // R7

    AST_THR_MATCHES_BIN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($rose(cal_done) && !$past(thr_wr_en)) |-> (thr_value == THR_TABLE[div_code])); // R4

    AST_CODE_STABLE_WHEN_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cal_done && $past(cal_done)) |-> $stable(div_code)); // R5

    AST_CODE_CHANGES_ONLY_ON_LOAD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(div_code) |-> $rose(cal_done)); // R8

    AST_NO_DONE_DURING_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        q.gate |-> !cal_done); // R2
endmodule

// File: tb/test_speed_calibrator.sv
`timescale 1ns/1ps
module test_speed_calibrator;
    localparam int WIN = 1024;

    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0;
    logic        thr_wr_en = 1'b0;
    logic [11:0] thr_wr_data = '0;
    logic [1:0]  div_code;
    logic [11:0] thr_value;
    logic        cal_done;

    real osc_half = 1.0;

    always #4 ref_clk = ~ref_clk;
    always #(osc_half) osc_clk = ~osc_clk;

    speed_calibrator i_speed_calibrator (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .osc_clk     (osc_clk),
        .test_en     (test_en),
        .thr_wr_en   (thr_wr_en),
        .thr_wr_data (thr_wr_data),
        .div_code    (div_code),
        .thr_value   (thr_value),
        .cal_done    (cal_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    bit m_active = 0;
    bit m_busy   = 0;
    bit m_done   = 0;
    int m_div    = 3;
    int m_thr    = 0;
    int since    = 0;
    int want_code = 3;

    function automatic int thr_of(int code);
        case (code)
            0: return 160;
            1: return 80;
            2: return 40;
            default: return 20;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        if (thr_wr_en) m_thr = int'(thr_wr_data);
        if (!test_en) begin
            m_active = 0; m_busy = 0; m_done = 0;
        end else if (!m_active) begin
            m_active = 1; m_busy = 1; since = 0;
        end else if (m_busy) begin
            since++;
        end
        @(posedge ref_clk);
        @(negedge ref_clk);
        if (m_busy && cal_done) begin
            chk(since >= WIN + 2, "R2", "done too early", since, WIN + 2);
            m_busy = 0; m_done = 1;
            m_div = want_code;
            m_thr = thr_of(want_code);
        end else if (m_busy && since > WIN + 16) begin
            chk(0, "R2", "done too late", since, WIN + 16);
        end
        chk(cal_done == m_done, m_busy ? "R2" : "R6", "cal_done", int'(cal_done), int'(m_done));
        chk(int'(div_code) == m_div, m_busy ? "R8" : "R3", "div_code", int'(div_code), m_div);
        chk(int'(thr_value) == m_thr, m_done ? "R4" : "R7", "thr_value", int'(thr_value), m_thr);
    endtask

    task automatic idle(int n);
        test_en = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_cal(real half, int code, int hold);
        osc_half = half;
        want_code = code;
        idle(20);
        test_en = 1;
        for (int i = 0; i < WIN + 40 && (m_busy || i == 0); i++) step();
        chk(m_done, "R2", "calibration completed", int'(m_done), 1);
        for (int i = 0; i < hold; i++) step();
    endtask

    initial begin
        // R1: reset values
        repeat (3) begin
            @(negedge ref_clk);
            chk(int'(div_code) == 3, "R1", "reset div_code", int'(div_code), 3);
            chk(int'(thr_value) == 0, "R1", "reset thr_value", int'(thr_value), 0);
            chk(cal_done == 1'b0, "R1", "reset cal_done", int'(cal_done), 0);
        end
        rst_n = 1;
        idle(5);

        // R3 R4: fastest bin, then R5 stable hold and R7 write after done
        run_cal(1.0, 0, 30);
        thr_wr_en = 1; thr_wr_data = 12'd777;
        step();
        thr_wr_en = 0;
        for (int i = 0; i < 20; i++) step();

        // R6: drop enable, outputs hold, done clears
        idle(20);

        // R3: slowest bin
        run_cal(8.0, 3, 10);

        // R8 R7: write early in a window, code held until load
        osc_half = 2.0; want_code = 1;
        idle(20);
        test_en = 1;
        for (int i = 0; i < 10; i++) step();
        thr_wr_en = 1; thr_wr_data = 12'd999;
        step();
        thr_wr_en = 0;
        for (int i = 0; i < WIN + 40 && m_busy; i++) step();
        chk(m_done, "R8", "calibration after write completed", int'(m_done), 1);
        for (int i = 0; i < 10; i++) step();

        // R6: abort mid-window, nothing loaded
        osc_half = 4.0; want_code = 2;
        idle(20);
        test_en = 1;
        for (int i = 0; i < 100; i++) step();
        idle(30);
        chk(int'(div_code) == 1, "R6", "code after abort", int'(div_code), 1);
        chk(int'(thr_value) == 80, "R6", "threshold after abort", int'(thr_value), 80);

        // R3: middle bins
        run_cal(4.0, 2, 10);
        run_cal(1.5, 1, 10);
        idle(5);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule